// File: doc/BRIEF.md
# Phase-Aligned Clock Divider with Gated Start

This block takes one clock and produces a set of divided versions of it, by default at one half, one quarter and one eighth of the input rate. One counter, clocked by the input clock, produces all of them, so wherever two outputs both switch, they switch on the same input edge. The outputs, read together as a binary number, count down by one on every rising input edge while the divider runs. All outputs rise together whenever that count wraps from zero to all-ones.

A run request is captured on the falling edge of the input clock. The counter may only start or stop at its rest state, where every output is low. A stop request therefore lets the current slow cycle finish, so no output ever carries a shortened pulse. An active-low master reset clears the counter at once and is released through a synchronizer. Several instances that leave reset on the same edge, with the run request held high, stay phase-locked to each other.

Top module: `sync_clk_divider`

## Requirements
- R1: While `rst_n_i` is low, every bit of `div_o` is low.
- R2: While running, `div_o` read as an unsigned number decreases by one, modulo 2^STAGES, on every rising edge of `clk_i`. Bit k therefore has a period of 2^(k+1) input cycles, with a high time of 2^k cycles. Bit 0 is the divide-by-2 output.
- R3: Any change of `div_o[k]` for k ≥ 1 happens on the same rising edge as a rise of `div_o[k-1]`. Every rise of the slowest output coincides with a rise of all faster outputs.
- R4: If `rst_n_i` rises between clock edges with `en_i` held high, `div_o` stays 0 through the first two rising edges after the release and becomes all-ones on the third.
- R5: `en_i` is sampled only on the falling edge of `clk_i`. A high pulse on `en_i` that starts and ends within one high phase of the clock has no effect on `div_o`.
- R6: When `div_o` is 0 and `en_i` was sampled high on a falling edge, `div_o` becomes all-ones on the next rising edge.
- R7: When `en_i` is sampled low, the count continues until it reaches 0 and then holds at 0. `div_o` stays 0 for as long as the sampled `en_i` stays low.
- R8: No output carries a runt pulse. Every high pulse of `div_o[k]` lasts exactly 2^k cycles, and every low interval between two of its pulses lasts at least 2^k cycles.
- R9: A fall of `rst_n_i` between clock edges clears `div_o` to 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_n_i | input | 1 | Master reset, active low. Assertion is asynchronous; release is synchronized. |
| en_i | input | 1 | Run request, sampled on the falling clock edge |
| div_o | output | STAGES | Divided outputs. Bit k runs at the input rate divided by 2^(k+1). |

## Verification
The assertions assume that `en_i` is stable around each falling clock edge. They also assume that every reset pulse spans at least one rising edge, so that the sample taken before the release shows a cleared counter. The stimulus meets both conditions. It changes `en_i` shortly after a rising edge, and it holds any reset for several whole cycles before releasing it between edges. Enable glitches are confined to the high phase, well clear of the falling edge where the enable is sampled.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Default number of divider stages (one output per stage).
  localparam int unsigned DEF_STAGES = 3;
  // Default depth of the reset release synchronizer.
  localparam int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic [SYNC_STAGES-1:0] sh_d;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      assign sh_d = 1'b1;
    end else begin : g_multi
      assign sh_d = {sh_q[SYNC_STAGES-2:0], 1'b1};
    end
  endgenerate

  // Reset asserts at once and is released after SYNC_STAGES rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/clkdiv_en_capture.sv
module clkdiv_en_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic en_smp_o
);
  logic en_q;

  // Sample the run request while the clock is entering its low phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_i;
  end

  assign en_smp_o = en_q;
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_smp_i,
  output logic [STAGES-1:0] cnt_o
);
  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_d;
  logic [STAGES-1:0] borrow;
  logic              at_rest;
  logic              advance;

  // Start or stop is only allowed at the all-low rest state.
  assign at_rest = (cnt_q == '0);
  assign advance = !at_rest || en_smp_i;

  assign borrow[0] = advance;
  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_borrow
      assign borrow[k] = advance && (cnt_q[k-1:0] == '0);
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q ^ borrow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (advance) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sync_clk_divider.sv
module sync_clk_divider #(
  parameter int unsigned STAGES      = clkdiv_pkg::DEF_STAGES,
  parameter int unsigned SYNC_STAGES = clkdiv_pkg::DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  output logic [STAGES-1:0] div_o
);
  logic rst_sync_n;
  logic en_smp;

  clkdiv_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk_i),
    .rst_n      (rst_n_i),
    .rst_sync_n (rst_sync_n)
  );

  clkdiv_en_capture u_en (
    .clk      (clk_i),
    .rst_n    (rst_sync_n),
    .en_i     (en_i),
    .en_smp_o (en_smp)
  );

  clkdiv_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk_i),
    .rst_n    (rst_sync_n),
    .en_smp_i (en_smp),
    .cnt_o    (div_o)
  );
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker #(
  parameter int unsigned STAGES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_smp,
  input logic [STAGES-1:0] div
);
  localparam logic [STAGES-1:0] ONE  = STAGES'(1);
  localparam logic [STAGES-1:0] ONES = '1;

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (div == '0);
    end
  end

  // R2: a running count moves down by exactly one.
  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div) != '0) |-> (div == $past(div) - ONE));

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_align
      // R3: a slower output only switches when the next faster one rises.
      assert_edge_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div[k] != $past(div[k])) |-> $rose(div[k-1]));
    end
  endgenerate

  // R6: leaving rest needs the falling-edge sample to be high.
  assert_start_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(div) == '0) && (div != '0)) |-> $past(en_smp));

  // R6: a start from rest raises every output together.
  assert_start_all_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(div) == '0) && $past(en_smp)) |-> (div == ONES));

  // R7: with the sample low, rest is held.
  assert_rest_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(div) == '0) && !$past(en_smp)) |-> (div == '0));
endmodule

bind sync_clk_divider clkdiv_checker #(.STAGES(STAGES)) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_n_i),
  .en_smp (en_smp),
  .div    (div_o)
);

// File: tb/test_sync_clk_divider.sv
`timescale 1ns/1ps
module test_sync_clk_divider;
  localparam int N = 3;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic en;
  logic [N-1:0] div_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [N-1:0] ref_cnt;
  int           ref_sync;
  logic         ref_enq;
  logic [N-1:0] prev_div;
  bit           prev_ok;
  int           run_len [N];
  bit           run_valid [N];

  sync_clk_divider #(.STAGES(N), .SYNC_STAGES(SYNC)) i_sync_clk_divider (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .en_i    (en),
    .div_o   (div_o)
  );

  always #10 clk = ~clk;

  function automatic logic [N-1:0] exp_next(logic [N-1:0] c, logic e);
    if (c == '0 && !e) return '0;
    return c - 1'b1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_track();
    prev_ok = 0;
    for (int k = 0; k < N; k++) begin
      run_len[k] = 0;
      run_valid[k] = 0;
    end
  endtask

  task automatic compare();
    check(div_o == ref_cnt, "R2 count", int'(div_o), int'(ref_cnt));
    if (prev_ok) begin
      for (int k = 1; k < N; k++)
        if (div_o[k] != prev_div[k])
          check(prev_div[k-1] == 1'b0 && div_o[k-1] == 1'b1, "R3 align", int'(div_o), int'(prev_div));
      for (int k = 0; k < N; k++) begin
        if (div_o[k] == prev_div[k]) run_len[k]++;
        else begin
          if (run_valid[k]) begin
            if (prev_div[k]) check(run_len[k] == (1 << k), "R8 high width", run_len[k], 1 << k);
            else             check(run_len[k] >= (1 << k), "R8 low width", run_len[k], 1 << k);
          end
          run_valid[k] = 1;
          run_len[k] = 1;
        end
      end
    end
    prev_div = div_o;
    prev_ok = 1;
  endtask

  // One clock cycle: model the rising edge, compare, drive, model the falling edge.
  task automatic step(logic e, bit pulse, logic r);
    @(posedge clk);
    if (!rst_n) begin
      ref_sync = 0;
      ref_cnt = '0;
    end else begin
      if (ref_sync == SYNC) ref_cnt = exp_next(ref_cnt, ref_enq);
      if (ref_sync < SYNC) ref_sync++;
    end
    #2;
    compare();
    rst_n = r;
    if (!r) begin
      ref_cnt = '0;
      ref_sync = 0;
      ref_enq = 1'b0;
      #1;
      check(div_o == '0, "R9 async clear", int'(div_o), 0);
      clear_track();
    end
    if (pulse) begin
      en = 1'b1;
      #5;
      en = 1'b0;
    end else begin
      en = e;
    end
    @(negedge clk);
    ref_enq = (rst_n && ref_sync == SYNC) ? en : 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    en = 1'b1;
    ref_cnt = '0;
    ref_sync = 0;
    ref_enq = 1'b0;
    prev_div = '0;
    clear_track();

    // R1: outputs held low in reset.
    for (int i = 0; i < 4; i++) step(1'b1, 0, 1'b0);
    check(div_o == '0, "R1 reset low", int'(div_o), 0);

    // R4: release between edges, first rise on the third rising edge.
    step(1'b1, 0, 1'b1);
    step(1'b1, 0, 1'b1);
    check(div_o == '0, "R4 edge1", int'(div_o), 0);
    step(1'b1, 0, 1'b1);
    check(div_o == '0, "R4 edge2", int'(div_o), 0);
    step(1'b1, 0, 1'b1);
    check(div_o == '1, "R4 edge3", int'(div_o), (1 << N) - 1);

    // R2/R8: steady run.
    for (int i = 0; i < 40; i++) step(1'b1, 0, 1'b1);

    // R7: stop request mid-count drains to rest and holds.
    while (div_o == '0) step(1'b1, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b0, 0, 1'b1);
    check(div_o == '0, "R7 rest reached", int'(div_o), 0);
    for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b1);
    check(div_o == '0, "R7 rest held", int'(div_o), 0);

    // R5: enable pulse confined to the high phase is ignored.
    step(1'b0, 1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b1);
    check(div_o == '0, "R5 glitch ignored", int'(div_o), 0);

    // R6: start from rest on the edge after the falling-edge sample.
    step(1'b1, 0, 1'b1);
    step(1'b1, 0, 1'b1);
    check(div_o == '1, "R6 start", int'(div_o), (1 << N) - 1);

    // R9: asynchronous reset mid-count.
    for (int i = 0; i < 3; i++) step(1'b1, 0, 1'b1);
    step(1'b1, 0, 1'b0);
    step(1'b1, 0, 1'b0);
    step(1'b1, 0, 1'b0);
    step(1'b1, 0, 1'b1);

    // Random enable traffic with occasional glitches and resets.
    for (int i = 0; i < 3000; i++) begin
      int unsigned roll = $urandom_range(0, 299);
      if (roll == 0) begin
        step(en, 0, 1'b0);
        step(en, 0, 1'b0);
        step(en, 0, 1'b1);
      end else if (roll < 20) begin
        step(1'b0, 1, 1'b1);
      end else if (roll < 90) begin
        step(~en, 0, 1'b1);
      end else begin
        step(en, 0, 1'b1);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule